// File: doc/BRIEF.md
# Auto-Incrementing Indexed Register Port

This block is the register front end of a sector-buffer controller. A host reaches sixteen byte-wide locations through one 4-bit index and one data port. Each data-port read or write acts on the location the index selects, and the index then steps to the next location. Consecutive fields can therefore be streamed without reloading the index. The read side and the write side decode the index against two different maps. Several accesses carry side effects: status recomputation, acknowledgement of pending events, and a full controller reset.

The decode and transfer engines sit outside the block. They reach it through two event strobes and through the registered fields (the data-transfer address is brought out as a port). A single interrupt request merges the two pending sources, the block-decoded event and the transfer-end event. Each source has its own enable, and a global enable input gates the result.

Top module: `idx_reg_port`

## Requirements
- R1: After reset the interface status reads 0xFF, status 3 reads 0x80, header bytes 0..3 of the current bank read 00 00 00 01, every other readable location reads 0x00, rd_data_o is 0x00, irq_o is 0 and xfer_addr_o is 0.
- R2: A data-port access at index 1..14 leaves the index one higher. A read at index 15 leaves it at 0. Any access at index 0 leaves it at 0, and an index write loads idx_i. When rd_en_i and wr_en_i are both high, only the write takes place and rd_data_o keeps its old value.
- R3: The write map is 2/3 byte count low/high, 4/5 transfer address low/high (seen on xfer_addr_o), 8/9 write pointer low/high and 12/13 block pointer low/high. On the read side, the byte count is at 2/3, the block pointer at 8/9 and the write pointer at 10/11.
- R4: A read returns the selected byte on rd_data_o from the cycle after rd_en_i, and the value holds until the next read. Index 0 reads 0xFF and index 13 (status 1) always reads 0x00.
- R5: Read indices 4..7 return header bytes 0..3: byte k is hdr bits [8k+7:8k]. When control 1 bit 0 is 1 they come from the previous bank, otherwise from the current bank. A dec_event_i pulse while control 0 bit 7 is 1 moves the current bank to the previous bank, loads hdr_i into the current bank, sets status 3 to 0x00 and drives interface status bit 5 low. While control 0 bit 7 is 0 the pulse is ignored.
- R6: A write to index 10 (control 0) sets status 0 to the written bit 7 alone. Status 2 becomes control 1 masked by 0x08 if the written bit 4 is 1, otherwise control 1 masked by 0x0C.
- R7: A write to index 11 (control 1) recomputes status 2 from the new value, using the same masking rule as R6 and the stored control 0 bit 4.
- R8: A write to index 7 drives interface status bit 6 high and clears byte count bits 15:12.
- R9: A read at index 15 returns the present status 3. Afterwards status 3 is 0x80 and interface status bit 5 is high. If dec_event_i arrives in that same cycle, the event's effects win.
- R10: A write to index 6 while interface control bit 1 is 1 drives interface status bit 3 low and clears byte count bits 15:12. While interface control bit 1 is 0 it has no effect. A write to index 1 stores interface control, and if the written bit 1 is 0 it drives interface status bits 3 and 1 high.
- R11: An xfer_end_i pulse loads the byte count with 0xF000, drives interface status bits 3 and 1 high and drives bit 6 low. It takes priority over an acknowledge in the same cycle.
- R12: irq_o is high when irq_en_i is high and either interface control bit 6 is 1 with status bit 6 low, or control bit 5 is 1 with status bit 5 low.
- R13: A write to index 15 returns every register and the index to the R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 1 | Load the index |
| idx_i | input | 4 | New index value |
| wr_en_i | input | 1 | Data-port write strobe |
| wr_data_i | input | 8 | Data-port write byte |
| rd_en_i | input | 1 | Data-port read strobe |
| rd_data_o | output | 8 | Byte returned by the last read |
| dec_event_i | input | 1 | Decoded-block event strobe |
| hdr_i | input | 32 | Header of the decoded block |
| xfer_end_i | input | 1 | Transfer-end event strobe |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| xfer_addr_o | output | 16 | Transfer address register |

## Verification
A read of status 3 acknowledges the decoder event, and a new decoded block raises it again. Both can land on the same clock edge. The bench raises rd_en_i at index 15 in the same cycle as a dec_event_i pulse. It then expects the old status 3 on rd_data_o, interface status bit 5 still low, the interrupt still asserted, and status 3 reading 0x00 on the next visit. The transfer-end strobe takes priority over the acknowledge write in the same way, and an assertion guards the acknowledge only in cycles without that strobe.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int IW = 4;
  localparam int DW = 8;
  localparam int HB = 4;
  localparam int HW = 8 * HB;

  // write map
  localparam logic [IW-1:0] WA_IFCTRL = 4'd1;
  localparam logic [IW-1:0] WA_BCNT_L = 4'd2;
  localparam logic [IW-1:0] WA_BCNT_H = 4'd3;
  localparam logic [IW-1:0] WA_XADR_L = 4'd4;
  localparam logic [IW-1:0] WA_XADR_H = 4'd5;
  localparam logic [IW-1:0] WA_TRIG   = 4'd6;
  localparam logic [IW-1:0] WA_ACK    = 4'd7;
  localparam logic [IW-1:0] WA_WPTR_L = 4'd8;
  localparam logic [IW-1:0] WA_WPTR_H = 4'd9;
  localparam logic [IW-1:0] WA_CTL0   = 4'd10;
  localparam logic [IW-1:0] WA_CTL1   = 4'd11;
  localparam logic [IW-1:0] WA_BLK_L  = 4'd12;
  localparam logic [IW-1:0] WA_BLK_H  = 4'd13;
  localparam logic [IW-1:0] WA_SRST   = 4'd15;

  // read map
  localparam logic [IW-1:0] RA_IFSTAT = 4'd1;
  localparam logic [IW-1:0] RA_BCNT_L = 4'd2;
  localparam logic [IW-1:0] RA_BCNT_H = 4'd3;
  localparam logic [IW-1:0] RA_BLK_L  = 4'd8;
  localparam logic [IW-1:0] RA_BLK_H  = 4'd9;
  localparam logic [IW-1:0] RA_WPTR_L = 4'd10;
  localparam logic [IW-1:0] RA_WPTR_H = 4'd11;
  localparam logic [IW-1:0] RA_ST0    = 4'd12;
  localparam logic [IW-1:0] RA_ST1    = 4'd13;
  localparam logic [IW-1:0] RA_ST2    = 4'd14;
  localparam logic [IW-1:0] RA_ST3    = 4'd15;

  // bit positions
  localparam int IFS_DTE_N  = 6;
  localparam int IFS_DEC_N  = 5;
  localparam int IFS_BUSY_N = 3;
  localparam int IFS_DATA_N = 1;
  localparam int IFC_DTE_EN = 6;
  localparam int IFC_DEC_EN = 5;
  localparam int IFC_OUT_EN = 1;
  localparam int C0_DEC_EN  = 7;
  localparam int C0_AUTO    = 4;
  localparam int C1_HSEL    = 0;

  typedef struct packed {
    logic [DW-1:0]   ifctrl;
    logic [DW-1:0]   ifstat;
    logic [2*DW-1:0] bcnt;
    logic [2*DW-1:0] xadr;
    logic [2*DW-1:0] wptr;
    logic [2*DW-1:0] blk;
    logic [DW-1:0]   ctl0;
    logic [DW-1:0]   ctl1;
    logic [HW-1:0]   hdr_cur;
    logic [HW-1:0]   hdr_prev;
    logic [DW-1:0]   st0;
    logic [DW-1:0]   st2;
    logic [DW-1:0]   st3;
  } regs_t;

  localparam regs_t REGS_RST = '{
    ifctrl: '0, ifstat: 8'hFF, bcnt: '0, xadr: '0, wptr: '0, blk: '0,
    ctl0: '0, ctl1: '0, hdr_cur: {8'h01, {(HW-8){1'b0}}}, hdr_prev: '0,
    st0: '0, st2: '0, st3: 8'h80};

  function automatic logic [DW-1:0] mode_form(input logic [DW-1:0] c1, input logic auto_m);
    return auto_m ? (c1 & 8'h08) : (c1 & 8'h0C);
  endfunction
endpackage

// File: rtl/irp_idx_ptr.sv
module irp_idx_ptr
  import irp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic [IW-1:0] idx_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = {IW{1'b1}};

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 idx_q <= '0;
    else if (idx_we_i)                           idx_q <= idx_i;
    else if (wr_en_i && idx_q == LAST)           idx_q <= '0;
    else if ((wr_en_i || rd_en_i) && idx_q != 0) idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  // R2
  zero_idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_we_i && idx_q == '0) |=> idx_q == '0);
  // R2
  rd_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_we_i && rd_en_i && !wr_en_i && idx_q == LAST) |=> idx_q == '0);
  // R2
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_we_i && (wr_en_i || rd_en_i) && idx_q != '0 && idx_q != LAST)
      |=> idx_q == IW'($past(idx_q) + 1'b1));
endmodule

// File: rtl/irp_reg_bank.sv
module irp_reg_bank
  import irp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          dec_event_i,
  input  logic [HW-1:0] hdr_i,
  input  logic          xfer_end_i,
  input  logic          irq_en_i,
  output regs_t         regs_o,
  output logic          irq_o
);
  regs_t r_q, r_d;
  logic  srst;

  always_comb begin
    r_d  = r_q;
    srst = 1'b0;
    if (wr_en_i) begin
      case (idx_i)
        WA_IFCTRL: begin
          if (!wr_data_i[IFC_OUT_EN]) begin
            r_d.ifstat[IFS_BUSY_N] = 1'b1;
            r_d.ifstat[IFS_DATA_N] = 1'b1;
          end
          r_d.ifctrl = wr_data_i;
        end
        WA_BCNT_L: r_d.bcnt[DW-1:0]    = wr_data_i;
        WA_BCNT_H: r_d.bcnt[2*DW-1:DW] = wr_data_i;
        WA_XADR_L: r_d.xadr[DW-1:0]    = wr_data_i;
        WA_XADR_H: r_d.xadr[2*DW-1:DW] = wr_data_i;
        WA_TRIG: begin
          if (r_q.ifctrl[IFC_OUT_EN]) begin
            r_d.ifstat[IFS_BUSY_N] = 1'b0;
            r_d.bcnt[15:12]        = 4'h0;
          end
        end
        WA_ACK: begin
          r_d.ifstat[IFS_DTE_N] = 1'b1;
          r_d.bcnt[15:12]       = 4'h0;
        end
        WA_WPTR_L: r_d.wptr[DW-1:0]    = wr_data_i;
        WA_WPTR_H: r_d.wptr[2*DW-1:DW] = wr_data_i;
        WA_CTL0: begin
          r_d.st0  = {wr_data_i[C0_DEC_EN], 7'b0};
          r_d.st2  = mode_form(r_q.ctl1, wr_data_i[C0_AUTO]);
          r_d.ctl0 = wr_data_i;
        end
        WA_CTL1: begin
          r_d.st2  = mode_form(wr_data_i, r_q.ctl0[C0_AUTO]);
          r_d.ctl1 = wr_data_i;
        end
        WA_BLK_L: r_d.blk[DW-1:0]    = wr_data_i;
        WA_BLK_H: r_d.blk[2*DW-1:DW] = wr_data_i;
        WA_SRST:  srst = 1'b1;
        default: ;
      endcase
    end else if (rd_en_i && idx_i == RA_ST3) begin
      r_d.st3               = 8'h80;
      r_d.ifstat[IFS_DEC_N] = 1'b1;
    end
    // engine events win over same-cycle acknowledges
    if (dec_event_i && r_q.ctl0[C0_DEC_EN]) begin
      r_d.hdr_prev          = r_q.hdr_cur;
      r_d.hdr_cur           = hdr_i;
      r_d.st3               = 8'h00;
      r_d.ifstat[IFS_DEC_N] = 1'b0;
    end
    if (xfer_end_i) begin
      r_d.bcnt               = 16'hF000;
      r_d.ifstat[IFS_BUSY_N] = 1'b1;
      r_d.ifstat[IFS_DATA_N] = 1'b1;
      r_d.ifstat[IFS_DTE_N]  = 1'b0;
    end
    if (srst) r_d = REGS_RST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= REGS_RST;
    else         r_q <= r_d;
  end

  assign regs_o = r_q;
  assign irq_o  = irq_en_i &
                  ((r_q.ifctrl[IFC_DTE_EN] & ~r_q.ifstat[IFS_DTE_N]) |
                   (r_q.ifctrl[IFC_DEC_EN] & ~r_q.ifstat[IFS_DEC_N]));

  logic wr_srst;
  assign wr_srst = wr_en_i && idx_i == WA_SRST;

  // R9
  st3_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && idx_i == RA_ST3 && !dec_event_i)
      |=> (r_q.st3 == 8'h80 && r_q.ifstat[IFS_DEC_N]));
  // R8
  dte_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == WA_ACK && !xfer_end_i)
      |=> (r_q.ifstat[IFS_DTE_N] && r_q.bcnt[15:12] == 4'h0));
  // R11
  xfer_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_end_i && !wr_srst) |=> (r_q.bcnt == 16'hF000 && !r_q.ifstat[IFS_DTE_N]));
  // R13
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_srst |=> r_q == REGS_RST);
  // R5
  dec_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_event_i && !r_q.ctl0[C0_DEC_EN] && !wr_srst) |=> $stable(r_q.hdr_cur));
endmodule

// File: rtl/irp_rd_mux.sv
module irp_rd_mux
  import irp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_ok_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [DW-1:0]   ifstat_i,
  input  logic [2*DW-1:0] bcnt_i,
  input  logic [2*DW-1:0] blk_i,
  input  logic [2*DW-1:0] wptr_i,
  input  logic [HW-1:0]   hdr_cur_i,
  input  logic [HW-1:0]   hdr_prev_i,
  input  logic            hdr_sel_i,
  input  logic [DW-1:0]   st0_i,
  input  logic [DW-1:0]   st2_i,
  input  logic [DW-1:0]   st3_i,
  output logic [DW-1:0]   rd_data_o
);
  logic [DW-1:0] hdr_b [HB];
  logic [DW-1:0] val;
  logic [DW-1:0] rd_q;

  for (genvar g = 0; g < HB; g++) begin : g_hdr
    assign hdr_b[g] = hdr_sel_i ? hdr_prev_i[8*g +: 8] : hdr_cur_i[8*g +: 8];
  end

  always_comb begin
    if (idx_i[3:2] == 2'b01) val = hdr_b[idx_i[1:0]];
    else begin
      case (idx_i)
        RA_IFSTAT: val = ifstat_i;
        RA_BCNT_L: val = bcnt_i[DW-1:0];
        RA_BCNT_H: val = bcnt_i[2*DW-1:DW];
        RA_BLK_L:  val = blk_i[DW-1:0];
        RA_BLK_H:  val = blk_i[2*DW-1:DW];
        RA_WPTR_L: val = wptr_i[DW-1:0];
        RA_WPTR_H: val = wptr_i[2*DW-1:DW];
        RA_ST0:    val = st0_i;
        RA_ST1:    val = '0;
        RA_ST2:    val = st2_i;
        RA_ST3:    val = st3_i;
        default:   val = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_ok_i) rd_q <= val;
  end

  assign rd_data_o = rd_q;

  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ok_i |=> $stable(rd_q));
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
  import irp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic [3:0]    idx_i,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_en_i,
  output logic [7:0]    rd_data_o,
  input  logic          dec_event_i,
  input  logic [31:0]   hdr_i,
  input  logic          xfer_end_i,
  input  logic          irq_en_i,
  output logic          irq_o,
  output logic [15:0]   xfer_addr_o
);
  logic [IW-1:0] idx;
  regs_t         regs;
  logic          rd_ok;

  assign rd_ok = rd_en_i & ~wr_en_i;

  irp_idx_ptr u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_we_i (idx_we_i),
    .idx_i    (idx_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .idx_o    (idx)
  );

  irp_reg_bank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_en_i     (rd_en_i),
    .dec_event_i (dec_event_i),
    .hdr_i       (hdr_i),
    .xfer_end_i  (xfer_end_i),
    .irq_en_i    (irq_en_i),
    .regs_o      (regs),
    .irq_o       (irq_o)
  );

  irp_rd_mux u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_ok_i    (rd_ok),
    .idx_i      (idx),
    .ifstat_i   (regs.ifstat),
    .bcnt_i     (regs.bcnt),
    .blk_i      (regs.blk),
    .wptr_i     (regs.wptr),
    .hdr_cur_i  (regs.hdr_cur),
    .hdr_prev_i (regs.hdr_prev),
    .hdr_sel_i  (regs.ctl1[C1_HSEL]),
    .st0_i      (regs.st0),
    .st2_i      (regs.st2),
    .st3_i      (regs.st3),
    .rd_data_o  (rd_data_o)
  );

  assign xfer_addr_o = regs.xadr;

  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);
endmodule

// File: tb/tb_idx_reg_port.sv
module tb_idx_reg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 1'b0;
  logic [3:0]  idx_v = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        dec_ev = 1'b0;
  logic [31:0] hdr = '0;
  logic        xend = 1'b0;
  logic        irq_en = 1'b1;
  logic        irq;
  logic [15:0] xaddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  idx_reg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(idx_we), .idx_i(idx_v),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .dec_event_i(dec_ev), .hdr_i(hdr), .xfer_end_i(xend), .irq_en_i(irq_en),
    .irq_o(irq), .xfer_addr_o(xaddr)
  );

  localparam logic [1:0] OP_IDX = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam int NV = 62;
  // {req, op, arg, expected}
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, OP_IDX, 8'h01, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'hFF}, // R1 interface status
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h00}, // header 0
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h01}, // header 3
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd4, OP_RD,  8'h00, 8'h00}, // R4 status 1
    {4'd1, OP_RD,  8'h00, 8'h00},
    {4'd1, OP_RD,  8'h00, 8'h80}, // R1 status 3
    {4'd4, OP_RD,  8'h00, 8'hFF}, // R4 index 0
    {4'd2, OP_RD,  8'h00, 8'hFF}, // R2 index stays 0
    {4'd3, OP_IDX, 8'h02, 8'h00},
    {4'd3, OP_WR,  8'h34, 8'h00},
    {4'd3, OP_WR,  8'h12, 8'h00},
    {4'd3, OP_WR,  8'h78, 8'h00},
    {4'd3, OP_WR,  8'h56, 8'h00},
    {4'd3, OP_IDX, 8'h08, 8'h00},
    {4'd3, OP_WR,  8'hBC, 8'h00},
    {4'd3, OP_WR,  8'h9A, 8'h00},
    {4'd6, OP_WR,  8'h10, 8'h00}, // R6 control 0, auto mode
    {4'd7, OP_WR,  8'h0D, 8'h00}, // R7 control 1
    {4'd3, OP_WR,  8'hEF, 8'h00},
    {4'd3, OP_WR,  8'hCD, 8'h00},
    {4'd2, OP_WR,  8'h00, 8'h00},
    {4'd9, OP_RD,  8'h00, 8'h80},
    {4'd2, OP_RD,  8'h00, 8'hFF}, // R2 wrapped
    {4'd3, OP_IDX, 8'h02, 8'h00},
    {4'd3, OP_RD,  8'h00, 8'h34},
    {4'd3, OP_RD,  8'h00, 8'h12},
    {4'd5, OP_RD,  8'h00, 8'h00}, // R5 previous bank
    {4'd5, OP_RD,  8'h00, 8'h00},
    {4'd5, OP_RD,  8'h00, 8'h00},
    {4'd5, OP_RD,  8'h00, 8'h00},
    {4'd3, OP_RD,  8'h00, 8'hEF},
    {4'd3, OP_RD,  8'h00, 8'hCD},
    {4'd3, OP_RD,  8'h00, 8'hBC},
    {4'd3, OP_RD,  8'h00, 8'h9A},
    {4'd6, OP_RD,  8'h00, 8'h00},
    {4'd4, OP_RD,  8'h00, 8'h00},
    {4'd7, OP_RD,  8'h00, 8'h08},
    {4'd9, OP_RD,  8'h00, 8'h80},
    {4'd6, OP_IDX, 8'h0A, 8'h00},
    {4'd6, OP_WR,  8'h80, 8'h00},
    {4'd6, OP_IDX, 8'h0C, 8'h00},
    {4'd6, OP_RD,  8'h00, 8'h80},
    {4'd4, OP_RD,  8'h00, 8'h00},
    {4'd6, OP_RD,  8'h00, 8'h0C},
    {4'd7, OP_IDX, 8'h0B, 8'h00},
    {4'd7, OP_WR,  8'h01, 8'h00},
    {4'd7, OP_IDX, 8'h0E, 8'h00},
    {4'd7, OP_RD,  8'h00, 8'h00},
    {4'd7, OP_IDX, 8'h0B, 8'h00},
    {4'd7, OP_WR,  8'h08, 8'h00},
    {4'd7, OP_IDX, 8'h0E, 8'h00},
    {4'd7, OP_RD,  8'h00, 8'h08}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [3:0] i);
    @(negedge clk); idx_we = 1'b1; idx_v = i;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic dec_pulse(input logic [31:0] h);
    @(negedge clk); dec_ev = 1'b1; hdr = h;
    @(negedge clk); dec_ev = 1'b0;
  endtask

  task automatic xend_pulse();
    @(negedge clk); xend = 1'b1;
    @(negedge clk); xend = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 xfer_addr", xaddr, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][17:16])
        OP_IDX:  set_idx(VEC[k][11:8]);
        OP_WR:   wr(VEC[k][15:8]);
        default: rd_chk($sformatf("R%0d vec%0d", VEC[k][21:18], k), VEC[k][7:0]);
      endcase
    end
    chk("R3 xfer_addr", xaddr, 16'h5678);

    // R5 decode event with decode enabled (control 0 = 80, control 1 = 08)
    dec_pulse(32'h44332211);
    set_idx(4);
    rd_chk("R5 cur0", 8'h11); rd_chk("R5 cur1", 8'h22);
    rd_chk("R5 cur2", 8'h33); rd_chk("R5 cur3", 8'h44);
    set_idx(11); wr(8'h09);
    set_idx(4);
    rd_chk("R5 prev0", 8'h00); rd_chk("R5 prev1", 8'h00);
    rd_chk("R5 prev2", 8'h00); rd_chk("R5 prev3", 8'h01);
    set_idx(1); rd_chk("R5 ifstat", 8'hDF);
    set_idx(15); rd_chk("R9 st3 old", 8'h00);
    rd_chk("R9 wrap", 8'hFF);
    set_idx(15); rd_chk("R9 st3 set", 8'h80);
    set_idx(1); rd_chk("R9 ifstat", 8'hFF);

    // R12 interrupt gating
    dec_pulse(32'h0);
    chk("R12 no enable", irq, 1'b0);
    set_idx(1); wr(8'h20);
    chk("R12 raise", irq, 1'b1);
    @(negedge clk); irq_en = 1'b0; #1;
    chk("R12 global off", irq, 1'b0);
    irq_en = 1'b1; #1;
    chk("R12 global on", irq, 1'b1);
    set_idx(15); rd_chk("R9 st3", 8'h00);
    chk("R12 ack drops", irq, 1'b0);

    // R5 event ignored with decode disabled
    set_idx(10); wr(8'h00);
    dec_pulse(32'hAABBCCDD);
    set_idx(1); rd_chk("R5 ignored ifstat", 8'hFF);
    set_idx(11); wr(8'h08);
    set_idx(4); rd_chk("R5 ignored hdr", 8'h00);

    // R9 status-3 read and decode event in one cycle
    set_idx(10); wr(8'h80);
    set_idx(15);
    @(negedge clk); rd_en = 1'b1; dec_ev = 1'b1; hdr = 32'h55667788;
    @(negedge clk); rd_en = 1'b0; dec_ev = 1'b0;
    chk("R9 collide rd", rd_data, 8'h80);
    chk("R9 collide irq", irq, 1'b1);
    set_idx(1); rd_chk("R9 collide ifstat", 8'hDF);
    set_idx(15); rd_chk("R9 collide st3", 8'h00);

    // R10 transfer trigger
    set_idx(1); wr(8'h02);
    set_idx(2); wr(8'h00); wr(8'hF4);
    set_idx(6); wr(8'h00);
    set_idx(1);
    rd_chk("R10 busy", 8'hF7); rd_chk("R10 bcnt lo", 8'h00); rd_chk("R10 bcnt hi", 8'h04);
    set_idx(1); wr(8'h00);
    set_idx(1); rd_chk("R10 out off", 8'hFF);
    set_idx(3); wr(8'hF4);
    set_idx(6); wr(8'h00);
    set_idx(1);
    rd_chk("R10 ign stat", 8'hFF); rd_chk("R10 ign lo", 8'h00); rd_chk("R10 ign hi", 8'hF4);

    // R11 transfer end, R8 acknowledge
    xend_pulse();
    set_idx(1);
    rd_chk("R11 ifstat", 8'hBF); rd_chk("R11 lo", 8'h00); rd_chk("R11 hi", 8'hF0);
    set_idx(7); wr(8'h00);
    set_idx(1);
    rd_chk("R8 ifstat", 8'hFF); rd_chk("R8 lo", 8'h00); rd_chk("R8 hi", 8'h00);
    set_idx(1); wr(8'h40);
    xend_pulse();
    chk("R12 dte irq", irq, 1'b1);
    set_idx(7); wr(8'h00);
    chk("R8 irq cleared", irq, 1'b0);

    // R2 simultaneous read and write
    set_idx(1); rd_chk("R2 pre", 8'hFF);
    set_idx(8);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    chk("R2 read dropped", rd_data, 8'hFF);
    rd_chk("R2 advanced", 8'hCD);
    set_idx(10); rd_chk("R2 write kept", 8'h5A);

    // R13 soft reset
    xend_pulse();
    chk("R13 pre irq", irq, 1'b1);
    set_idx(15); wr(8'h00);
    chk("R13 irq", irq, 1'b0);
    chk("R13 xfer_addr", xaddr, 16'h0000);
    rd_chk("R13 index", 8'hFF);
    set_idx(1); rd_chk("R13 ifstat", 8'hFF); rd_chk("R13 bcnt", 8'h00);
    set_idx(7); rd_chk("R13 hdr3", 8'h01);
    set_idx(10); rd_chk("R13 wptr", 8'h00);
    set_idx(14); rd_chk("R13 st2", 8'h00); rd_chk("R13 st3", 8'h80);

    finish_run();
  end
endmodule